// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a 64-bit count of nanoseconds for packet timestamping. On every enabled clock it adds a programmable increment to a wide accumulator. The increment is a fixed-point value: the upper register word holds whole nanoseconds and the lower word holds a 32-bit binary fraction. The same counter can therefore follow real time at clock periods that are not whole nanoseconds. The live integer nanosecond value is driven on `time_ns` for capture logic. The fraction stays internal.

Software reaches the block through a single-cycle 32-bit register port. Every 64-bit quantity is split into a low word and a high word:
- Reading the low time word returns the live low half and records the live high half in a snapshot. A later read of the high time word returns that snapshot, so the two reads form one coherent value.
- Writing the low time word only stages it. Writing the high word afterwards loads both halves into the counter at once.
- The increment follows the same stage-then-commit rule. A new rate therefore never applies with only one half updated.

Each staging path is a two-state machine:
- `SW_IDLE` moves to `SW_STAGED` on a low-word write.
- `SW_STAGED` stays in `SW_STAGED` on a further low-word write, which restages the word.
- `SW_STAGED` returns to `SW_IDLE` on a high-word write, which commits the 64-bit value.

There is one such machine for time and one for the increment.

Top module: `tod_counter`

## Requirements
- R1: After reset the time is zero, the increment is zero, the run bit is clear, and neither staging machine holds a word.
- R2: While the run bit is set and the increment is nonzero, each clock adds the 32.32 increment to a 64.32 accumulator. `time_ns` shows the integer part, including carries from the fraction. For example, 0x20_00000000 adds exactly 32 ns per clock.
- R3: While the run bit is clear, `time_ns` holds its value, except when a load occurs.
- R4: A committed increment of zero stops the time, even with the run bit set.
- R5: A read of the time-low word (offset 1) returns the live bits [31:0] and records bits [63:32]. A read of the time-high word (offset 2) returns the recorded half, not the live one.
- R6: A write to time-low only stages the word, and the counter keeps running meanwhile. A following write to time-high loads {high, low} into the counter and clears the fraction. `time_ns` shows the loaded value from the next clock on.
- R7: A write to time-high with no staged low word has no effect on the time.
- R8: A write to increment-low (offset 3) stages the word. A following write to increment-high (offset 4) commits {high, low}. The new increment is first added on the clock after the commit.
- R9: A write to increment-high with no staged low word leaves the increment unchanged.
- R10: When a time load and a tick fall on the same clock, the load wins. The next tick counts on from the loaded value.
- R11: Offset 0 holds the run bit in bit 0 and reads back with the upper bits zero. Both increment words read back the committed increment. Other offsets read zero, and `reg_rdata` is zero whenever `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational while `reg_rd` is high |
| time_ns | output | 64 | Live integer nanosecond time |

## Verification
The bench builds the block with its default 32-bit word width, so the accumulator is 96 bits wide and the increment is 32.32. This width puts the following within a few hundred clocks:
- A carry from the fraction into whole nanoseconds at the 1.6 ns-like rate.
- A carry from the low time word into the high word, by loading a value just below 2^32.
- A snapshot read that straddles that carry.

A behavioural model built on wide integer arithmetic tracks the counter on every clock. Explicit checks cover the exact 32 ns rate, load priority over a tick, and the ignored lone high-word writes.

// File: rtl/tod_pkg.sv
package tod_pkg;

    // Register word offsets; software depends on these values.
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_TIME_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_TIME_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_INC_LO  = 3'd3;
    localparam logic [ADDR_W-1:0] A_INC_HI  = 3'd4;

    // Number of split 64-bit channels: 0 = time, 1 = increment.
    localparam int N_CHAN = 2;
    localparam int CH_TIME = 0;
    localparam int CH_INC  = 1;

    typedef enum logic {
        SW_IDLE   = 1'b0,
        SW_STAGED = 1'b1
    } stage_st_e;

endpackage

// File: rtl/tod_stage_fsm.sv
module tod_stage_fsm
    import tod_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [DATA_W-1:0]     wdata,
    output logic                  commit,
    output logic [2*DATA_W-1:0]   commit_val,
    output logic                  staged
);

    stage_st_e         st_q, st_nx;
    logic [DATA_W-1:0] lo_q;

    // Next-state selection.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            SW_IDLE:   if (wr_lo) st_nx = SW_STAGED;
            SW_STAGED: if (wr_hi) st_nx = SW_IDLE;
            default:   st_nx = SW_IDLE;
        endcase
    end

    // State register and staged low word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SW_IDLE;
            lo_q <= '0;
        end else begin
            st_q <= st_nx;
            if (wr_lo) lo_q <= wdata;
        end
    end

    // Outputs.
    always_comb begin
        staged     = (st_q == SW_STAGED);
        commit     = (st_q == SW_STAGED) && wr_hi;
        commit_val = {wdata, lo_q};
    end

endmodule

// File: rtl/tod_reg_if.sv
module tod_reg_if
    import tod_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [2*DATA_W-1:0]   time_ns,
    output logic                  run,
    output logic [2*DATA_W-1:0]   inc,
    output logic                  load,
    output logic [2*DATA_W-1:0]   load_val,
    output logic [N_CHAN-1:0]     staged
);

    localparam int WIDE_W = 2 * DATA_W;

    logic [N_CHAN-1:0] commit;
    logic [WIDE_W-1:0] commit_val [N_CHAN];
    logic [DATA_W-1:0] snap_q;
    logic              run_q;
    logic [WIDE_W-1:0] inc_q;

    // One staging machine per split channel.
    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        localparam logic [ADDR_W-1:0] LO_A = (g == CH_TIME) ? A_TIME_LO : A_INC_LO;
        localparam logic [ADDR_W-1:0] HI_A = (g == CH_TIME) ? A_TIME_HI : A_INC_HI;
        tod_stage_fsm #(.DATA_W(DATA_W)) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_lo      (reg_wr && (reg_addr == LO_A)),
            .wr_hi      (reg_wr && (reg_addr == HI_A)),
            .wdata      (reg_wdata),
            .commit     (commit[g]),
            .commit_val (commit_val[g]),
            .staged     (staged[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            inc_q  <= '0;
            snap_q <= '0;
        end else begin
            if (reg_wr && (reg_addr == A_CTRL)) run_q <= reg_wdata[0];
            if (commit[CH_INC]) inc_q <= commit_val[CH_INC];
            if (reg_rd && (reg_addr == A_TIME_LO)) snap_q <= time_ns[WIDE_W-1:DATA_W];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                A_CTRL:    reg_rdata = {{(DATA_W-1){1'b0}}, run_q};
                A_TIME_LO: reg_rdata = time_ns[DATA_W-1:0];
                A_TIME_HI: reg_rdata = snap_q;
                A_INC_LO:  reg_rdata = inc_q[DATA_W-1:0];
                A_INC_HI:  reg_rdata = inc_q[WIDE_W-1:DATA_W];
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign run      = run_q;
    assign inc      = inc_q;
    assign load     = commit[CH_TIME];
    assign load_val = commit_val[CH_TIME];

endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
    parameter int NS_W   = 64,
    parameter int FRAC_W = 32,
    parameter int INC_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [INC_W-1:0]  inc,
    input  logic              load,
    input  logic [NS_W-1:0]   load_val,
    output logic [NS_W-1:0]   time_ns
);

    localparam int ACC_W = NS_W + FRAC_W;

    logic [ACC_W-1:0] acc_q;
    logic             tick;

    assign tick = run && (inc != '0);

    // Load has priority over the tick on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= {load_val, {FRAC_W{1'b0}}};
        end else if (tick) begin
            acc_q <= acc_q + ACC_W'(inc);
        end
    end

    assign time_ns = acc_q[ACC_W-1:FRAC_W];

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [2:0]            reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [2*DATA_W-1:0]   time_ns
);

    localparam int NS_W   = 2 * DATA_W;
    localparam int FRAC_W = DATA_W;
    localparam int INC_W  = 2 * DATA_W;

    logic              run_en;
    logic [INC_W-1:0]  inc_val;
    logic              time_load;
    logic [NS_W-1:0]   time_load_val;
    logic [N_CHAN-1:0] stage_flags;

    tod_reg_if #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .time_ns   (time_ns),
        .run       (run_en),
        .inc       (inc_val),
        .load      (time_load),
        .load_val  (time_load_val),
        .staged    (stage_flags)
    );

    tod_accum #(.NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en),
        .inc      (inc_val),
        .load     (time_load),
        .load_val (time_load_val),
        .time_ns  (time_ns)
    );

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [2:0]          reg_addr,
    input logic [2*DATA_W-1:0] time_ns,
    input logic                run_en,
    input logic [2*DATA_W-1:0] inc_val,
    input logic                time_load,
    input logic [2*DATA_W-1:0] time_load_val,
    input logic [1:0]          stage_flags
);

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !time_load) |=> (time_ns == $past(time_ns))); // R3

    AST_ZERO_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((inc_val == '0) && !time_load) |=> (time_ns == $past(time_ns))); // R4

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        time_load |=> (time_ns == $past(time_load_val))); // R10

    AST_NO_BACKWARD: assert property (@(posedge clk) disable iff (!rst_n)
        !time_load |=> (time_ns >= $past(time_ns))); // R2

    AST_LONE_INC_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 3'd4) && !stage_flags[1]) |=> (inc_val == $past(inc_val))); // R9

    AST_LONE_TIME_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 3'd2) && !stage_flags[0]) |-> !time_load); // R7

endmodule

bind tod_counter tod_counter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .time_ns       (time_ns),
    .run_en        (run_en),
    .inc_val       (inc_val),
    .time_load     (time_load),
    .time_load_val (time_load_val),
    .stage_flags   (stage_flags)
);

// File: tb/sim_tod_counter.sv
`timescale 1ns/1ps
module sim_tod_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] time_ns;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit model_live = 1'b0;

    // Behavioural reference state.
    bit [95:0] m_acc;
    bit [63:0] m_inc;
    bit        m_run;
    bit [31:0] m_snap;
    bit        m_tstg, m_istg;
    bit [31:0] m_tlo, m_ilo;

    always #2.5 clk = ~clk;

    tod_counter u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .time_ns(time_ns)
    );

    function automatic bit [63:0] m_ns();
        return m_acc[95:32];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0; m_inc = '0; m_run = 0; m_snap = '0;
            m_tstg = 0; m_istg = 0; m_tlo = '0; m_ilo = '0;
        end else begin
            bit [63:0] inc_before;
            bit        run_before;
            inc_before = m_inc;
            run_before = m_run;
            if (reg_rd && reg_addr == 3'd1) m_snap = m_acc[95:64];
            if (reg_wr && reg_addr == 3'd2 && m_tstg) begin
                m_acc = {reg_wdata, m_tlo, 32'h0};
                m_tstg = 0;
            end else if (run_before && inc_before != 0) begin
                m_acc = m_acc + {32'h0, inc_before};
            end
            if (reg_wr && reg_addr == 3'd0) m_run = reg_wdata[0];
            if (reg_wr && reg_addr == 3'd1) begin m_tlo = reg_wdata; m_tstg = 1; end
            if (reg_wr && reg_addr == 3'd3) begin m_ilo = reg_wdata; m_istg = 1; end
            if (reg_wr && reg_addr == 3'd4 && m_istg) begin
                m_inc = {reg_wdata, m_ilo};
                m_istg = 0;
            end
        end
    end

    task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of the live time.
    always @(negedge clk) begin
        if (model_live) check64(cur_req, "time_ns per clock", time_ns, m_ns());
    end

    function automatic bit [31:0] m_rd(bit [2:0] a);
        case (a)
            3'd0: return {31'h0, m_run};
            3'd1: return m_acc[63:32];
            3'd2: return m_snap;
            3'd3: return m_inc[31:0];
            3'd4: return m_inc[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic wr(bit [2:0] a, bit [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(bit [2:0] a, string req, output logic [31:0] val);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1;
        val = reg_rdata;
        check64(req, "register read", {32'h0, reg_rdata}, {32'h0, m_rd(a)});
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_sim();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_sim();
    end

    initial begin
        logic [31:0] v, v2;
        logic [63:0] t0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        model_live = 1;

        // R1: reset state
        cur_req = "R1";
        check64("R1", "time after reset", time_ns, 64'h0);
        rd(3'd0, "R1", v);
        check64("R1", "run bit after reset", {32'h0, v}, 64'h0);
        rd(3'd4, "R1", v);
        check64("R1", "inc high after reset", {32'h0, v}, 64'h0);

        // R11: unmapped offset and idle read bus
        cur_req = "R11";
        rd(3'd7, "R11", v);
        check64("R11", "unmapped read", {32'h0, v}, 64'h0);
        check64("R11", "rdata idle", {32'h0, reg_rdata}, 64'h0);

        // R9: lone increment-high write ignored
        cur_req = "R9";
        wr(3'd4, 32'h5);
        rd(3'd4, "R9", v);
        check64("R9", "inc high after lone write", {32'h0, v}, 64'h0);

        // R8 / R3: commit 1.6-ish ns increment, run still off
        cur_req = "R8";
        wr(3'd3, 32'h99999999);
        idle(2);
        rd(3'd4, "R8", v);
        check64("R8", "inc not committed yet", {32'h0, v}, 64'h0);
        wr(3'd4, 32'h1);
        rd(3'd3, "R8", v);
        check64("R8", "inc low committed", {32'h0, v}, 64'h99999999);
        cur_req = "R3";
        idle(5);
        check64("R3", "time held while run off", time_ns, 64'h0);

        // R2: fractional counting
        cur_req = "R2";
        wr(3'd0, 32'h1);
        idle(40);
        rd(3'd0, "R11", v);
        check64("R11", "run bit reads back", {32'h0, v}, 64'h1);

        // R6: stage low, then load; R10: load while ticking
        cur_req = "R6";
        wr(3'd1, 32'hFFFFFF00);
        idle(6);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h20);
        cur_req = "R10";
        wr(3'd2, 32'h0);
        check64("R10", "loaded value wins", time_ns, 64'h00000000_FFFFFF00);
        @(negedge clk);
        check64("R2", "exact 32 ns step", time_ns, 64'h00000000_FFFFFF20);

        // R5: snapshot across the low-to-high carry
        cur_req = "R5";
        rd(3'd1, "R5", v);
        idle(12);
        check64("R5", "live high carried", {32'h0, time_ns[63:32]}, 64'h1);
        rd(3'd2, "R5", v2);
        check64("R5", "high read is snapshot", {32'h0, v2}, 64'h0);

        // R7: lone time-high write ignored
        cur_req = "R7";
        wr(3'd2, 32'hABCD);
        check64("R7", "time high unaffected", {32'h0, time_ns[63:32]}, 64'h1);
        idle(3);

        // R4: zero increment stops the time
        cur_req = "R4";
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h0);
        t0 = time_ns;
        idle(6);
        check64("R4", "time held with zero inc", time_ns, t0);

        // R3: run off stops the time with nonzero increment
        cur_req = "R3";
        wr(3'd3, 32'h33333333);
        wr(3'd4, 32'h3);
        idle(10);
        wr(3'd0, 32'h0);
        t0 = time_ns;
        idle(6);
        check64("R3", "time held after run cleared", time_ns, t0);

        // R6: load while stopped, fraction cleared
        cur_req = "R6";
        wr(3'd1, 32'h1000);
        wr(3'd2, 32'h7);
        check64("R6", "load while stopped", time_ns, 64'h00000007_00001000);
        wr(3'd0, 32'h1);
        idle(20);

        cur_req = "R2";
        idle(2);
        finish_sim();
    end

endmodule